// File: doc/BRIEF.md
# SMBus Host Transaction Sequencer

This block runs a complete SMBus transaction on the host side, one at a time. The caller presents an operation code, a 7-bit target address, a command byte, a block count and a PEC enable, then pulses `start`. The sequencer walks through the framing that the operation needs: START, address bytes, the command byte, any write data, a repeated START to turn the bus around, read data, an optional CRC-8 packet-error byte, and STOP. It drives a byte-level primitive engine that takes care of the bit timing on the wires.

The primitive engine is a level request and pulse reply handshake. `prim_req` stays high with a stable `prim_op`, `prim_wdata` and `prim_nack` until the engine returns a one-cycle `prim_done`. For a write primitive, `prim_ack` carries the acknowledge sampled from the target. For a read primitive, `prim_rdata` carries the received byte. Write data is fetched from a caller-side buffer through the `wr_idx`/`wr_byte` lookup. Read data leaves the block as a stream of one-cycle `rd_valid` pulses.

A missing acknowledge, a device-supplied block count that cannot be valid, or a bad PEC byte ends the transfer early with STOP. Each of these leaves an error code that is valid at `done`.

Top module: `smbus_host_seq`

## Requirements
- R1: Operation codes on `cmd_op` are 0 quick, 1 send byte, 2 receive byte, 3 write byte, 4 read byte, 5 write word, 6 read word, 7 process call, 8 block write, 9 block read. Primitive codes on `prim_op` are 0 START, 1 repeated START, 2 STOP, 3 write byte, 4 read byte. An address byte is `{addr, dir}`, with dir 1 for read and 0 for write. `prim_req` with its `prim_op` is held until `prim_done`.
- R2: A quick command issues START, then writes `{addr, cmd_code[0]}`, then STOP. It carries no data and no PEC byte.
- R3: Send byte issues START, the write address, buffer byte 0 and STOP. Write byte and write word issue START, the write address, `cmd_code`, then buffer bytes 0..n-1 (n = 1 or 2), then STOP.
- R4: Read byte, read word and block read issue START, the write address and `cmd_code`, then a repeated START, the read address and the read bytes. Receive byte goes straight from START to the read address.
- R5: Every read byte is acknowledged (`prim_nack` = 0) except the last byte before STOP, which is sent `prim_nack` = 1. When PEC is on, that last byte is the PEC byte.
- R6: Word data travels low byte first in both directions. Buffer index 0 and `rd_idx` 0 are the low byte.
- R7: A process call writes the address, `cmd_code`, and buffer bytes 0 and 1. It then turns around with a repeated START and the read address, and reads two bytes.
- R8: In a block read, the first byte after the read address is a count that is not delivered on the read stream. Exactly that many data bytes follow. A count of 0 or above MAX_BLOCK (32) is followed directly by STOP and error code 2.
- R9: A block write sends `cmd_count` right after `cmd_code`, then buffer bytes 0..count-1.
- R10: With `cmd_pec` set, a CRC-8 is computed with polynomial 0x07, initial value 0, MSB first, over every address, command, count and data byte of the transfer. It is written, or read and compared, just before STOP. A mismatch on a read gives error code 3.
- R11: A write primitive answered with `prim_ack` = 0 is followed directly by STOP and error code 1.
- R12: `start` is accepted only when the block is idle. `busy` rises the cycle after acceptance and falls the cycle after the one-cycle `done` pulse. `err` (0 means no error) is valid at `done`.
- R13: Each received data byte appears on `rd_byte` with its index on `rd_idx`, marked by a one-cycle `rd_valid` in the cycle after its `prim_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transaction (taken only when idle) |
| cmd_op | input | 4 | Operation code |
| cmd_addr | input | 7 | Target address |
| cmd_code | input | 8 | Command byte; bit 0 is the quick-command data bit |
| cmd_count | input | 6 | Block write byte count |
| cmd_pec | input | 1 | Enable packet error checking |
| wr_idx | output | 6 | Index of the write byte requested from the buffer |
| wr_byte | input | 8 | Buffer byte at `wr_idx` |
| prim_req | output | 1 | Primitive request, held until `prim_done` |
| prim_op | output | 3 | Primitive code |
| prim_wdata | output | 8 | Byte for a write primitive |
| prim_nack | output | 1 | For a read primitive: 1 sends NACK |
| prim_done | input | 1 | Primitive complete (one cycle) |
| prim_ack | input | 1 | Acknowledge received on a write primitive |
| prim_rdata | input | 8 | Byte returned by a read primitive |
| rd_valid | output | 1 | Read data byte valid |
| rd_idx | output | 6 | Index of the read data byte |
| rd_byte | output | 8 | Read data byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Transaction finished (one cycle) |
| err | output | 2 | 0 none, 1 missing ACK, 2 bad block count, 3 PEC mismatch |

## Verification
A new `start` can land in the same cycle as the `done` pulse of the previous transaction, because `busy` is still high there. The bench raises `start` exactly in the cycle where it sees `done` and holds it for one clock. It then checks that no START primitive follows and that `busy` stays low afterwards. A second pairing covers the received count byte of a block read and the start of data delivery. The count byte must produce no `rd_valid` pulse, while the data byte that follows it must be indexed from 0.

// File: rtl/smbus_host_pkg.sv
package smbus_host_pkg;

   typedef enum logic [3:0] {
      OP_QUICK  = 4'd0,
      OP_SEND   = 4'd1,
      OP_RECV   = 4'd2,
      OP_WRBYTE = 4'd3,
      OP_RDBYTE = 4'd4,
      OP_WRWORD = 4'd5,
      OP_RDWORD = 4'd6,
      OP_PCALL  = 4'd7,
      OP_BLKWR  = 4'd8,
      OP_BLKRD  = 4'd9
   } smb_op_e;

   typedef enum logic [2:0] {
      PR_START  = 3'd0,
      PR_RSTART = 3'd1,
      PR_STOP   = 3'd2,
      PR_WRITE  = 3'd3,
      PR_READ   = 3'd4
   } prim_e;

   typedef enum logic [1:0] {
      ER_NONE  = 2'd0,
      ER_NACK  = 2'd1,
      ER_COUNT = 2'd2,
      ER_PEC   = 2'd3
   } err_e;

   typedef enum logic [3:0] {
      ST_IDLE, ST_START, ST_ADDRW, ST_CMD, ST_WCNT, ST_WDATA, ST_RSTART,
      ST_ADDRR, ST_RCNT, ST_RDATA, ST_PECTX, ST_PECRX, ST_STOP, ST_DONE
   } seq_st_e;

endpackage

// File: rtl/smbus_pec_crc.sv
module smbus_pec_crc #(
   parameter int         W    = 8,
   parameter logic [W-1:0] POLY = 8'h07
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   input  logic [W-1:0] din,
   output logic [W-1:0] crc
);

   if (W < 2) begin : g_bad_width
      $error("smbus_pec_crc: W must be at least 2");
   end

   // One byte, most significant bit first.
   function automatic logic [W-1:0] crc_step(input logic [W-1:0] c, input logic [W-1:0] d);
      logic [W-1:0] r;
      r = c;
      for (int i = W - 1; i >= 0; i--) begin
         if (r[W-1] ^ d[i]) r = (r << 1) ^ POLY;
         else               r = r << 1;
      end
      return r;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  crc <= '0;
      else if (clr) crc <= '0;
      else if (en)  crc <= crc_step(crc, din);
   end

endmodule

// File: rtl/smbus_byte_ctr.sv
module smbus_byte_ctr #(
   parameter int IW = 6
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [IW-1:0] len,
   input  logic          step,
   output logic [IW-1:0] idx,
   output logic          last
);

   logic [IW-1:0] len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx   <= '0;
         len_q <= '0;
      end else if (load) begin
         idx   <= '0;
         len_q <= len;
      end else if (step) begin
         idx   <= idx + IW'(1);
      end
   end

   assign last = (idx == len_q - IW'(1));

endmodule

// File: rtl/smbus_host_seq.sv
module smbus_host_seq
   import smbus_host_pkg::*;
#(
   parameter int         MAX_BLOCK = 32,
   parameter bit         PEC_EN    = 1'b1,
   parameter logic [7:0] PEC_POLY  = 8'h07,
   localparam int        IW        = $clog2(MAX_BLOCK + 1)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [3:0]    cmd_op,
   input  logic [6:0]    cmd_addr,
   input  logic [7:0]    cmd_code,
   input  logic [IW-1:0] cmd_count,
   input  logic          cmd_pec,
   output logic [IW-1:0] wr_idx,
   input  logic [7:0]    wr_byte,
   output logic          prim_req,
   output logic [2:0]    prim_op,
   output logic [7:0]    prim_wdata,
   output logic          prim_nack,
   input  logic          prim_done,
   input  logic          prim_ack,
   input  logic [7:0]    prim_rdata,
   output logic          rd_valid,
   output logic [IW-1:0] rd_idx,
   output logic [7:0]    rd_byte,
   output logic          busy,
   output logic          done,
   output logic [1:0]    err
);

   if (MAX_BLOCK < 1 || MAX_BLOCK > 255) begin : g_bad_max
      $error("smbus_host_seq: MAX_BLOCK must lie in 1..255");
   end

   seq_st_e       st, st_nx;
   smb_op_e       op_q, op_in;
   err_e          err_q, err_nx;
   logic [6:0]    addr_q;
   logic [7:0]    code_q;
   logic [IW-1:0] cnt_q;
   logic          pec_q;
   logic [7:0]    crc;
   logic          accept, is_wr_step, crc_en, rcnt_ok;
   logic          ctr_load, ctr_step, ctr_last;
   logic [IW-1:0] ctr_len, ctr_idx, wlen_in, rlen;
   seq_st_e       wr_tail;

   assign op_in   = smb_op_e'(cmd_op);
   assign accept  = (st == ST_IDLE) && start;
   assign rcnt_ok = (prim_rdata != 8'd0) && (prim_rdata <= 8'(MAX_BLOCK));
   assign wr_tail = pec_q ? ST_PECTX : ST_STOP;

   assign is_wr_step = (st == ST_ADDRW) || (st == ST_ADDRR) || (st == ST_CMD) ||
                       (st == ST_WCNT)  || (st == ST_WDATA) || (st == ST_PECTX);

   // Write length comes from the command inputs while they are accepted.
   always_comb begin
      case (op_in)
         OP_WRWORD, OP_PCALL: wlen_in = IW'(2);
         OP_BLKWR:            wlen_in = cmd_count;
         default:             wlen_in = IW'(1);
      endcase
      rlen = (op_q == OP_RDWORD || op_q == OP_PCALL) ? IW'(2) : IW'(1);
   end

   always_comb begin
      st_nx  = st;
      err_nx = err_q;
      unique case (st)
         ST_IDLE: if (start) st_nx = ST_START;
         ST_DONE: st_nx = ST_IDLE;
         default: if (prim_done) begin
            if (is_wr_step && !prim_ack) begin
               st_nx  = ST_STOP;
               err_nx = ER_NACK;
            end else begin
               case (st)
                  ST_START:  st_nx = (op_q == OP_RECV) ? ST_ADDRR : ST_ADDRW;
                  ST_ADDRW:  st_nx = (op_q == OP_QUICK) ? ST_STOP :
                                     (op_q == OP_SEND)  ? ST_WDATA : ST_CMD;
                  ST_CMD: begin
                     case (op_q)
                        OP_BLKWR:                       st_nx = ST_WCNT;
                        OP_WRBYTE, OP_WRWORD, OP_PCALL: st_nx = ST_WDATA;
                        default:                        st_nx = ST_RSTART;
                     endcase
                  end
                  ST_WCNT:   st_nx = (cnt_q == '0) ? wr_tail : ST_WDATA;
                  ST_WDATA:  if (ctr_last) st_nx = (op_q == OP_PCALL) ? ST_RSTART : wr_tail;
                  ST_RSTART: st_nx = ST_ADDRR;
                  ST_ADDRR:  st_nx = (op_q == OP_BLKRD) ? ST_RCNT : ST_RDATA;
                  ST_RCNT: begin
                     if (rcnt_ok) st_nx = ST_RDATA;
                     else begin
                        st_nx  = ST_STOP;
                        err_nx = ER_COUNT;
                     end
                  end
                  ST_RDATA:  if (ctr_last) st_nx = pec_q ? ST_PECRX : ST_STOP;
                  ST_PECTX:  st_nx = ST_STOP;
                  ST_PECRX: begin
                     st_nx = ST_STOP;
                     if (prim_rdata != crc) err_nx = ER_PEC;
                  end
                  ST_STOP:   st_nx = ST_DONE;
                  default:   st_nx = st;
               endcase
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         err_q    <= ER_NONE;
         op_q     <= OP_QUICK;
         addr_q   <= '0;
         code_q   <= '0;
         cnt_q    <= '0;
         pec_q    <= 1'b0;
         rd_valid <= 1'b0;
         rd_idx   <= '0;
         rd_byte  <= '0;
      end else begin
         st       <= st_nx;
         err_q    <= accept ? ER_NONE : err_nx;
         rd_valid <= prim_done && (st == ST_RDATA);
         if (prim_done && st == ST_RDATA) begin
            rd_idx  <= ctr_idx;
            rd_byte <= prim_rdata;
         end
         if (accept) begin
            op_q   <= op_in;
            addr_q <= cmd_addr;
            code_q <= cmd_code;
            cnt_q  <= cmd_count;
            pec_q  <= cmd_pec && PEC_EN && (op_in != OP_QUICK);
         end
      end
   end

   // Shared byte counter: write phase, then reloaded for the read phase.
   assign ctr_load = accept ||
                     (prim_done && st == ST_ADDRR && op_q != OP_BLKRD) ||
                     (prim_done && st == ST_RCNT);
   assign ctr_len  = accept ? wlen_in : (st == ST_RCNT) ? prim_rdata[IW-1:0] : rlen;
   assign ctr_step = prim_done && (st == ST_WDATA || st == ST_RDATA);

   smbus_byte_ctr #(.IW(IW)) i_ctr (
      .clk  (clk),
      .rst_n(rst_n),
      .load (ctr_load),
      .len  (ctr_len),
      .step (ctr_step),
      .idx  (ctr_idx),
      .last (ctr_last)
   );

   assign crc_en = prim_done &&
                   (st == ST_ADDRW || st == ST_ADDRR || st == ST_CMD || st == ST_WCNT ||
                    st == ST_WDATA || st == ST_RCNT  || st == ST_RDATA);

   if (PEC_EN) begin : g_pec
      smbus_pec_crc #(.W(8), .POLY(PEC_POLY)) i_crc (
         .clk  (clk),
         .rst_n(rst_n),
         .clr  (accept),
         .en   (crc_en),
         .din  ((prim_op == PR_READ) ? prim_rdata : prim_wdata),
         .crc  (crc)
      );
   end else begin : g_nopec
      assign crc = '0;
   end

   always_comb begin
      prim_req   = (st != ST_IDLE) && (st != ST_DONE);
      prim_nack  = 1'b0;
      prim_wdata = '0;
      case (st)
         ST_START:  prim_op = PR_START;
         ST_RSTART: prim_op = PR_RSTART;
         ST_STOP:   prim_op = PR_STOP;
         ST_RCNT, ST_RDATA, ST_PECRX: prim_op = PR_READ;
         default:   prim_op = PR_WRITE;
      endcase
      case (st)
         ST_ADDRW:  prim_wdata = {addr_q, (op_q == OP_QUICK) ? code_q[0] : 1'b0};
         ST_ADDRR:  prim_wdata = {addr_q, 1'b1};
         ST_CMD:    prim_wdata = code_q;
         ST_WCNT:   prim_wdata = 8'(cnt_q);
         ST_WDATA:  prim_wdata = wr_byte;
         ST_PECTX:  prim_wdata = crc;
         ST_RDATA:  prim_nack  = ctr_last && !pec_q;
         ST_PECRX:  prim_nack  = 1'b1;
         default:   prim_wdata = '0;
      endcase
   end

   assign wr_idx = ctr_idx;
   assign busy   = (st != ST_IDLE);
   assign done   = (st == ST_DONE);
   assign err    = err_q;

endmodule

// File: rtl/smbus_host_seq_chk.sv
module smbus_host_seq_chk
   import smbus_host_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       busy,
   input logic       done,
   input logic       prim_req,
   input logic       prim_done,
   input logic [2:0] prim_op,
   input logic       rd_valid
);

   // R1: a request holds with a stable code until it is answered
   p_req_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (prim_req && !prim_done) |=> (prim_req && $stable(prim_op)));

   // R12: done lasts one cycle
   p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R12: busy drops only after done
   p_busy_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(done));

   // R12: busy rises only from an accepted start
   p_busy_rise_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   // R11: every transaction, including an aborted one, closes with a completed STOP
   p_stop_before_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(prim_done) && $past(prim_op) == PR_STOP));

   // R13: read data appears only inside a transaction
   p_rd_in_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> busy);

endmodule

bind smbus_host_seq smbus_host_seq_chk i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .busy     (busy),
   .done     (done),
   .prim_req (prim_req),
   .prim_done(prim_done),
   .prim_op  (prim_op),
   .rd_valid (rd_valid)
);

// File: tb/test_smbus_host_seq.sv
`timescale 1ns/1ps
module test_smbus_host_seq;
   import smbus_host_pkg::*;

   localparam int BIW = 6;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [3:0]     cmd_op = '0;
   logic [6:0]     cmd_addr = '0;
   logic [7:0]     cmd_code = '0;
   logic [BIW-1:0] cmd_count = '0;
   logic           cmd_pec = 1'b0;
   logic [BIW-1:0] wr_idx;
   logic [7:0]     wr_byte;
   logic           prim_req;
   logic [2:0]     prim_op;
   logic [7:0]     prim_wdata;
   logic           prim_nack;
   logic           prim_done = 1'b0;
   logic           prim_ack = 1'b0;
   logic [7:0]     prim_rdata = '0;
   logic           rd_valid;
   logic [BIW-1:0] rd_idx;
   logic [7:0]     rd_byte;
   logic           busy, done;
   logic [1:0]     err;

   logic [7:0] wbuf [32];
   assign wr_byte = wbuf[wr_idx[4:0]];

   always #2 clk = ~clk;

   smbus_host_seq i_smbus_host_seq (.*);

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  finished = 0;

   typedef struct {
      logic [2:0] op;
      logic [7:0] wd;
      bit         chkw;
      logic       nack;
      bit         chkn;
      logic       ack;
      logic [7:0] rd;
      string      tag;
   } prim_item_t;

   typedef struct {
      logic [BIW-1:0] idx;
      logic [7:0]     b;
      string          tag;
   } rd_item_t;

   prim_item_t pq[$];
   rd_item_t   rq[$];
   logic [7:0] bcrc;

   task automatic chk(input string tag, input bit ok, input string what, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [7:0] crc_upd(input logic [7:0] c, input logic [7:0] d);
      logic [7:0] r;
      r = c;
      for (int i = 7; i >= 0; i--) begin
         if (r[7] ^ d[i]) r = (r << 1) ^ 8'h07;
         else             r = r << 1;
      end
      return r;
   endfunction

   // ---------------- driver-side expectation builders ----------------
   task automatic exp_p(input logic [2:0] op, input string tag);
      prim_item_t it;
      it = '{op: op, wd: 8'h00, chkw: 0, nack: 1'b0, chkn: 0, ack: 1'b1, rd: 8'h00, tag: tag};
      pq.push_back(it);
   endtask

   task automatic exp_w(input logic [7:0] b, input logic ack, input string tag);
      prim_item_t it;
      it = '{op: PR_WRITE, wd: b, chkw: 1, nack: 1'b0, chkn: 0, ack: ack, rd: 8'h00, tag: tag};
      pq.push_back(it);
      bcrc = crc_upd(bcrc, b);
   endtask

   task automatic exp_r(input logic [7:0] b, input logic nack, input bit deliver,
                        input int idx, input string tag);
      prim_item_t it;
      rd_item_t   ri;
      it = '{op: PR_READ, wd: 8'h00, chkw: 0, nack: nack, chkn: 1, ack: 1'b1, rd: b, tag: tag};
      pq.push_back(it);
      bcrc = crc_upd(bcrc, b);
      if (deliver) begin
         ri = '{idx: BIW'(idx), b: b, tag: tag};
         rq.push_back(ri);
      end
   endtask

   task automatic exp_pec_tx(input string tag);
      prim_item_t it;
      it = '{op: PR_WRITE, wd: bcrc, chkw: 1, nack: 1'b0, chkn: 0, ack: 1'b1, rd: 8'h00, tag: tag};
      pq.push_back(it);
   endtask

   task automatic exp_pec_rx(input logic [7:0] flip, input string tag);
      prim_item_t it;
      it = '{op: PR_READ, wd: 8'h00, chkw: 0, nack: 1'b1, chkn: 1, ack: 1'b1, rd: bcrc ^ flip, tag: tag};
      pq.push_back(it);
   endtask

   task automatic go(input smb_op_e op, input logic [6:0] a, input logic [7:0] code,
                     input int cnt, input bit pec);
      @(negedge clk);
      start     = 1'b1;
      cmd_op    = op;
      cmd_addr  = a;
      cmd_code  = code;
      cmd_count = BIW'(cnt);
      cmd_pec   = pec;
      @(negedge clk);
      start = 1'b0;
      chk("R12", busy == 1'b1, "busy after accept", busy, 1);
   endtask

   task automatic wait_done(input logic [1:0] exp_err, input string tag, input bit inject);
      int n;
      n = 0;
      while (!done && n < 3000) begin
         @(negedge clk);
         n++;
      end
      chk(tag, done == 1'b1, "done seen", done, 1);
      chk(tag, err == exp_err, "err at done", err, exp_err);
      chk(tag, pq.size() == 0, "primitives left", pq.size(), 0);
      chk(tag, rq.size() == 0, "read bytes left", rq.size(), 0);
      if (inject) begin
         // start arrives in the done cycle: busy is still high, so it must be ignored
         start  = 1'b1;
         cmd_op = OP_QUICK;
         @(negedge clk);
         start = 1'b0;
         for (int k = 0; k < 6; k++) begin
            chk("R12", !prim_req && !busy, "start in done cycle taken", {prim_req, busy}, 0);
            @(negedge clk);
         end
      end else begin
         @(negedge clk);
      end
   endtask

   // ---------------- monitor: bus responder + read stream scoreboard ----------------
   initial begin
      prim_item_t it;
      forever begin
         @(negedge clk);
         if (prim_done) begin
            prim_done = 1'b0;
         end else if (prim_req) begin
            if (pq.size() == 0) begin
               chk("R12", 1'b0, "unexpected primitive op", prim_op, 7);
               prim_ack = 1'b0;
            end else begin
               it = pq.pop_front();
               chk(it.tag, prim_op == it.op, "prim_op", prim_op, it.op);
               if (it.chkw) chk(it.tag, prim_wdata == it.wd, "prim_wdata", prim_wdata, it.wd);
               if (it.chkn) chk("R5", prim_nack == it.nack, "prim_nack", prim_nack, it.nack);
               prim_ack   = it.ack;
               prim_rdata = it.rd;
            end
            prim_done = 1'b1;
         end
      end
   end

   initial begin
      rd_item_t ri;
      forever begin
         @(negedge clk);
         if (rd_valid) begin
            if (rq.size() == 0) begin
               chk("R13", 1'b0, "unexpected rd_valid", rd_byte, 0);
            end else begin
               ri = rq.pop_front();
               chk("R13", rd_idx == ri.idx, "rd_idx", rd_idx, ri.idx);
               chk(ri.tag, rd_byte == ri.b, "rd_byte", rd_byte, ri.b);
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      for (int i = 0; i < 32; i++) wbuf[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12", !busy && !done && !prim_req && err == 2'd0, "reset state",
          {busy, done, prim_req, err}, 0);

      // R2: quick command, data bit 1, no PEC even when requested
      bcrc = 0;
      exp_p(PR_START, "R2"); exp_w(8'h55, 1'b1, "R2"); exp_p(PR_STOP, "R2");
      go(OP_QUICK, 7'h2A, 8'h01, 0, 1'b1);
      wait_done(2'd0, "R2", 0);

      // R3: write byte
      bcrc = 0; wbuf[0] = 8'hA5;
      exp_p(PR_START, "R3"); exp_w(8'h20, 1'b1, "R1"); exp_w(8'h3C, 1'b1, "R3");
      exp_w(8'hA5, 1'b1, "R3"); exp_p(PR_STOP, "R3");
      go(OP_WRBYTE, 7'h10, 8'h3C, 0, 1'b0);
      wait_done(2'd0, "R3", 0);

      // R6 / R10: write word, low byte first, PEC appended
      bcrc = 0; wbuf[0] = 8'h34; wbuf[1] = 8'h12;
      exp_p(PR_START, "R6"); exp_w(8'h22, 1'b1, "R6"); exp_w(8'h07, 1'b1, "R6");
      exp_w(8'h34, 1'b1, "R6"); exp_w(8'h12, 1'b1, "R6"); exp_pec_tx("R10");
      exp_p(PR_STOP, "R10");
      go(OP_WRWORD, 7'h11, 8'h07, 0, 1'b1);
      wait_done(2'd0, "R10", 0);

      // R4 / R5 / R6: read word with turnaround
      bcrc = 0;
      exp_p(PR_START, "R4"); exp_w(8'h90, 1'b1, "R4"); exp_w(8'h05, 1'b1, "R4");
      exp_p(PR_RSTART, "R4"); exp_w(8'h91, 1'b1, "R4");
      exp_r(8'hCD, 1'b0, 1, 0, "R6"); exp_r(8'hAB, 1'b1, 1, 1, "R6");
      exp_p(PR_STOP, "R5");
      go(OP_RDWORD, 7'h48, 8'h05, 0, 1'b0);
      wait_done(2'd0, "R4", 0);

      // R10: receive byte with correct PEC, PEC byte is the NACKed one
      bcrc = 0;
      exp_p(PR_START, "R4"); exp_w(8'h19, 1'b1, "R4");
      exp_r(8'h5A, 1'b0, 1, 0, "R5"); exp_pec_rx(8'h00, "R10"); exp_p(PR_STOP, "R10");
      go(OP_RECV, 7'h0C, 8'h00, 0, 1'b1);
      wait_done(2'd0, "R10", 0);

      // R10: read byte, PEC mismatch gives error 3
      bcrc = 0;
      exp_p(PR_START, "R10"); exp_w(8'h18, 1'b1, "R10"); exp_w(8'h01, 1'b1, "R10");
      exp_p(PR_RSTART, "R10"); exp_w(8'h19, 1'b1, "R10");
      exp_r(8'h77, 1'b0, 1, 0, "R10"); exp_pec_rx(8'h01, "R10"); exp_p(PR_STOP, "R10");
      go(OP_RDBYTE, 7'h0C, 8'h01, 0, 1'b1);
      wait_done(2'd3, "R10", 0);

      // R7: process call
      bcrc = 0; wbuf[0] = 8'h11; wbuf[1] = 8'h22;
      exp_p(PR_START, "R7"); exp_w(8'h60, 1'b1, "R7"); exp_w(8'h02, 1'b1, "R7");
      exp_w(8'h11, 1'b1, "R7"); exp_w(8'h22, 1'b1, "R7"); exp_p(PR_RSTART, "R7");
      exp_w(8'h61, 1'b1, "R7"); exp_r(8'h33, 1'b0, 1, 0, "R7"); exp_r(8'h44, 1'b1, 1, 1, "R7");
      exp_p(PR_STOP, "R7");
      go(OP_PCALL, 7'h30, 8'h02, 0, 1'b0);
      wait_done(2'd0, "R7", 0);

      // R9: block write, count 3, with PEC
      bcrc = 0; wbuf[0] = 8'h01; wbuf[1] = 8'h02; wbuf[2] = 8'h03;
      exp_p(PR_START, "R9"); exp_w(8'h80, 1'b1, "R9"); exp_w(8'h09, 1'b1, "R9");
      exp_w(8'h03, 1'b1, "R9");
      for (int i = 0; i < 3; i++) exp_w(8'(i + 1), 1'b1, "R9");
      exp_pec_tx("R10"); exp_p(PR_STOP, "R9");
      go(OP_BLKWR, 7'h40, 8'h09, 3, 1'b1);
      wait_done(2'd0, "R9", 0);

      // R8: block read, count 4; the count byte is not streamed
      bcrc = 0;
      exp_p(PR_START, "R8"); exp_w(8'h82, 1'b1, "R8"); exp_w(8'h0A, 1'b1, "R8");
      exp_p(PR_RSTART, "R8"); exp_w(8'h83, 1'b1, "R8"); exp_r(8'h04, 1'b0, 0, 0, "R8");
      for (int i = 0; i < 4; i++) exp_r(8'(8'hF0 + i), (i == 3), 1, i, "R8");
      exp_p(PR_STOP, "R8");
      go(OP_BLKRD, 7'h41, 8'h0A, 0, 1'b0);
      wait_done(2'd0, "R8", 0);

      // R8 / R10: block read at the 32-byte limit with PEC
      bcrc = 0;
      exp_p(PR_START, "R8"); exp_w(8'h82, 1'b1, "R8"); exp_w(8'h0B, 1'b1, "R8");
      exp_p(PR_RSTART, "R8"); exp_w(8'h83, 1'b1, "R8"); exp_r(8'd32, 1'b0, 0, 0, "R8");
      for (int i = 0; i < 32; i++) exp_r(8'(i * 3 + 1), 1'b0, 1, i, "R8");
      exp_pec_rx(8'h00, "R10"); exp_p(PR_STOP, "R8");
      go(OP_BLKRD, 7'h41, 8'h0B, 0, 1'b1);
      wait_done(2'd0, "R8", 0);

      // R8: count 0 and count 33 are rejected
      bcrc = 0;
      exp_p(PR_START, "R8"); exp_w(8'h82, 1'b1, "R8"); exp_w(8'h0C, 1'b1, "R8");
      exp_p(PR_RSTART, "R8"); exp_w(8'h83, 1'b1, "R8"); exp_r(8'd0, 1'b0, 0, 0, "R8");
      exp_p(PR_STOP, "R8");
      go(OP_BLKRD, 7'h41, 8'h0C, 0, 1'b0);
      wait_done(2'd2, "R8", 0);

      bcrc = 0;
      exp_p(PR_START, "R8"); exp_w(8'h82, 1'b1, "R8"); exp_w(8'h0C, 1'b1, "R8");
      exp_p(PR_RSTART, "R8"); exp_w(8'h83, 1'b1, "R8"); exp_r(8'd33, 1'b0, 0, 0, "R8");
      exp_p(PR_STOP, "R8");
      go(OP_BLKRD, 7'h41, 8'h0C, 0, 1'b0);
      wait_done(2'd2, "R8", 0);

      // R11: NACK on the command byte ends the transfer
      bcrc = 0; wbuf[0] = 8'hEE;
      exp_p(PR_START, "R11"); exp_w(8'h44, 1'b1, "R11"); exp_w(8'h5E, 1'b0, "R11");
      exp_p(PR_STOP, "R11");
      go(OP_WRBYTE, 7'h22, 8'h5E, 0, 1'b0);
      wait_done(2'd1, "R11", 0);

      // R3 / R12: send byte, then a start raised in the done cycle
      bcrc = 0; wbuf[0] = 8'h99;
      exp_p(PR_START, "R3"); exp_w(8'h0A, 1'b1, "R3"); exp_w(8'h99, 1'b1, "R3");
      exp_p(PR_STOP, "R3");
      go(OP_SEND, 7'h05, 8'h00, 0, 1'b0);
      wait_done(2'd0, "R12", 1);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule